// File: doc/BRIEF.md
# GPIO Controller with Per-Pin Function Multiplexer

This block is a memory-mapped general-purpose I/O controller for a bank of 22 pads. It also decides, pin by pin, whether the pad is driven by the GPIO registers or by one of three peripheral signal sets. Software changes output bits through a direct-write register or through write-one-to-set and write-one-to-clear aliases. It programs direction in an output-enable register and reads pad levels back through a two-flop synchronizer.

Each pin carries a 2-bit function code. The low bit of the code sits in one select register and the high bit sits at the same bit position in a second select register. Code 0 selects GPIO. Codes 1, 2 and 3 route the pad to the pin's signal in peripheral set 1, 2 or 3. A constant per-pin presence table marks some of those slots as empty. An empty slot leaves the pad undriven. Each peripheral input port sees the synchronized pad level only while its slot is the one selected on that pin.

Top module: `gpio_padmux`

## Requirements
- R1: While reset is low, output value, output enable and both select registers are 0, so every pad has pad_oe = 0 and pad_out = 0, and every readable register returns 0.
- R2: A write to byte offset 0x00 (set alias) drives high each output bit written as 1 and leaves the bits written as 0 unchanged. A read of 0x00 returns 0.
- R3: A write to byte offset 0x04 (clear alias) drives low each output bit written as 1 and leaves the bits written as 0 unchanged. A read of 0x04 returns 0.
- R4: Offset 0x08 holds the output value. A write replaces it and a read returns it.
- R5: Offset 0x10 holds the output enable, where bit = 1 means output. On a pin in GPIO mode, pad_oe equals that bit and pad_out equals the output-value bit.
- R6: Offset 0x0C returns each pad level after two rising clock edges (two-flop synchronizer), not after one. Writes to 0x0C have no effect.
- R7: A pin's function code is {bit p of 0x24, bit p of 0x20}. Code 0 is GPIO on every pin.
- R8: With code k in 1..3 and the slot present, pad_out and pad_oe of pin p come from altk_out[p] and altk_oe[p] in the same cycle.
- R9: Empty slots drive pad_oe = 0 and pad_out = 0. Slot 1 is present on all pins. Slot 2 is empty on pins 0-3 and 16. Slot 3 is empty on pins 0-3, 6, 7 and 18-21.
- R10: altk_in[p] equals the synchronized level of pad p when pin p has code k and slot k is present, and 0 otherwise.
- R11: Bits 31..22 of every register read 0 and ignore writes. Offsets outside the map, such as 0x14, read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte offset of the register access |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pad_in | input | 22 | Pad input levels, asynchronous |
| pad_out | output | 22 | Pad output values |
| pad_oe | output | 22 | Pad output enables (1 = drive) |
| alt1_out | input | 22 | Peripheral set 1 output per pin |
| alt1_oe | input | 22 | Peripheral set 1 output enable per pin |
| alt1_in | output | 22 | Peripheral set 1 synchronized input per pin |
| alt2_out | input | 22 | Peripheral set 2 output per pin |
| alt2_oe | input | 22 | Peripheral set 2 output enable per pin |
| alt2_in | output | 22 | Peripheral set 2 synchronized input per pin |
| alt3_out | input | 22 | Peripheral set 3 output per pin |
| alt3_oe | input | 22 | Peripheral set 3 output enable per pin |
| alt3_in | output | 22 | Peripheral set 3 synchronized input per pin |

## Verification
A register write takes effect at the rising edge that samples it. From that edge, readback and the GPIO or multiplexed pad outputs change with no further latency. Peripheral outputs reach the pads within the same cycle. A pad input change appears in the input register and on the peripheral input ports only after the second rising edge. The bench drives every input on the falling edge and samples on a later falling edge. It checks the input register after exactly one edge, where the old value must still show, and after exactly two edges, where the new value must show.

// File: rtl/gpio_padmux_pkg.sv
package gpio_padmux_pkg;
  localparam int unsigned BUS_W   = 32;
  localparam int unsigned ADDR_W  = 8;
  localparam int unsigned NUM_ALT = 3;

  localparam logic [ADDR_W-1:0] OFS_SET   = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_CLR   = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_OUT   = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_IN    = 8'h0C;
  localparam logic [ADDR_W-1:0] OFS_OE    = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_SELLO = 8'h20;
  localparam logic [ADDR_W-1:0] OFS_SELHI = 8'h24;

  typedef enum logic [1:0] {
    FN_GPIO = 2'd0,
    FN_ALT1 = 2'd1,
    FN_ALT2 = 2'd2,
    FN_ALT3 = 2'd3
  } fn_code_e;

  // Two select registers hold the low and high bit of each pin's code.
  function automatic fn_code_e pin_code(input logic lo, input logic hi);
    return fn_code_e'({hi, lo});
  endfunction

  // Output-value update for the set/clear aliases.
  function automatic logic [BUS_W-1:0] apply_set(input logic [BUS_W-1:0] cur,
                                                 input logic [BUS_W-1:0] m);
    return cur | m;
  endfunction

  function automatic logic [BUS_W-1:0] apply_clr(input logic [BUS_W-1:0] cur,
                                                 input logic [BUS_W-1:0] m);
    return cur & ~m;
  endfunction
endpackage

// File: rtl/gpio_padmux_regs.sv
module gpio_padmux_regs
  import gpio_padmux_pkg::*;
#(
  parameter int unsigned NUM_PINS = 22
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   addr,
  input  logic                we,
  input  logic [BUS_W-1:0]    wdata,
  input  logic [NUM_PINS-1:0] sync_in,
  output logic [NUM_PINS-1:0] out_q,
  output logic [NUM_PINS-1:0] oe_q,
  output logic [NUM_PINS-1:0] sel_lo_q,
  output logic [NUM_PINS-1:0] sel_hi_q,
  output logic                ev_wr_set,
  output logic                ev_wr_clr,
  output logic [BUS_W-1:0]    rdata
);
  localparam int unsigned PAD_BITS = BUS_W - NUM_PINS;

  logic [NUM_PINS-1:0] wmask;
  logic ev_wr_out, ev_wr_oe, ev_wr_lo, ev_wr_hi;
  logic [BUS_W-1:0] out_ext;

  assign wmask     = wdata[NUM_PINS-1:0];
  assign ev_wr_set = we && (addr == OFS_SET);
  assign ev_wr_clr = we && (addr == OFS_CLR);
  assign ev_wr_out = we && (addr == OFS_OUT);
  assign ev_wr_oe  = we && (addr == OFS_OE);
  assign ev_wr_lo  = we && (addr == OFS_SELLO);
  assign ev_wr_hi  = we && (addr == OFS_SELHI);
  assign out_ext   = {{PAD_BITS{1'b0}}, out_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '0;
    end else if (ev_wr_set) begin
      out_q <= apply_set(out_ext, {{PAD_BITS{1'b0}}, wmask})[NUM_PINS-1:0];
    end else if (ev_wr_clr) begin
      out_q <= apply_clr(out_ext, {{PAD_BITS{1'b0}}, wmask})[NUM_PINS-1:0];
    end else if (ev_wr_out) begin
      out_q <= wmask;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe_q     <= '0;
      sel_lo_q <= '0;
      sel_hi_q <= '0;
    end else begin
      if (ev_wr_oe) oe_q     <= wmask;
      if (ev_wr_lo) sel_lo_q <= wmask;
      if (ev_wr_hi) sel_hi_q <= wmask;
    end
  end

  always_comb begin
    rdata = '0;
    unique case (addr)
      OFS_OUT:   rdata[NUM_PINS-1:0] = out_q;
      OFS_IN:    rdata[NUM_PINS-1:0] = sync_in;
      OFS_OE:    rdata[NUM_PINS-1:0] = oe_q;
      OFS_SELLO: rdata[NUM_PINS-1:0] = sel_lo_q;
      OFS_SELHI: rdata[NUM_PINS-1:0] = sel_hi_q;
      default:   rdata = '0;
    endcase
  end
endmodule

// File: rtl/gpio_padmux_sync.sv
module gpio_padmux_sync #(
  parameter int unsigned WIDTH  = 22,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
    end else begin
      stage_q[0] <= d;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_padmux_route.sv
module gpio_padmux_route
  import gpio_padmux_pkg::*;
#(
  parameter int unsigned NUM_PINS = 22
) (
  input  logic [NUM_PINS-1:0]               sel_lo,
  input  logic [NUM_PINS-1:0]               sel_hi,
  input  logic [NUM_PINS-1:0]               gpio_out,
  input  logic [NUM_PINS-1:0]               gpio_oe,
  input  logic [NUM_PINS-1:0]               pin_sync,
  input  logic [NUM_ALT-1:0][NUM_PINS-1:0]  slot_present,
  input  logic [NUM_ALT-1:0][NUM_PINS-1:0]  alt_out,
  input  logic [NUM_ALT-1:0][NUM_PINS-1:0]  alt_oe,
  output logic [NUM_ALT-1:0][NUM_PINS-1:0]  alt_in,
  output logic [NUM_PINS-1:0]               pad_out,
  output logic [NUM_PINS-1:0]               pad_oe
);
  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    fn_code_e code;
    logic     po, poe;

    assign code = pin_code(sel_lo[p], sel_hi[p]);

    always_comb begin
      po  = gpio_out[p];
      poe = gpio_oe[p];
      if (code != FN_GPIO) begin
        po  = 1'b0;
        poe = 1'b0;
        for (int k = 0; k < NUM_ALT; k++) begin
          if (code == fn_code_e'(k + 1) && slot_present[k][p]) begin
            po  = alt_out[k][p];
            poe = alt_oe[k][p];
          end
        end
      end
    end

    assign pad_out[p] = po;
    assign pad_oe[p]  = poe;

    for (genvar k = 0; k < NUM_ALT; k++) begin : g_slot
      assign alt_in[k][p] = (code == fn_code_e'(k + 1)) && slot_present[k][p] && pin_sync[p];
    end
  end
endmodule

// File: rtl/gpio_padmux.sv
module gpio_padmux
  import gpio_padmux_pkg::*;
#(
  parameter int unsigned        NUM_PINS  = 22,
  parameter logic [NUM_PINS-1:0] ALT1_MAP = 22'h3FFFFF,
  parameter logic [NUM_PINS-1:0] ALT2_MAP = 22'h3EFFF0,
  parameter logic [NUM_PINS-1:0] ALT3_MAP = 22'h03FF30
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [7:0]          bus_addr,
  input  logic                bus_we,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  input  logic [NUM_PINS-1:0] pad_in,
  output logic [NUM_PINS-1:0] pad_out,
  output logic [NUM_PINS-1:0] pad_oe,
  input  logic [NUM_PINS-1:0] alt1_out,
  input  logic [NUM_PINS-1:0] alt1_oe,
  output logic [NUM_PINS-1:0] alt1_in,
  input  logic [NUM_PINS-1:0] alt2_out,
  input  logic [NUM_PINS-1:0] alt2_oe,
  output logic [NUM_PINS-1:0] alt2_in,
  input  logic [NUM_PINS-1:0] alt3_out,
  input  logic [NUM_PINS-1:0] alt3_oe,
  output logic [NUM_PINS-1:0] alt3_in
);
  logic [NUM_PINS-1:0] gpio_out_q, gpio_oe_q, sel_lo_q, sel_hi_q, pin_sync;
  logic                ev_wr_set, ev_wr_clr;
  logic [NUM_ALT-1:0][NUM_PINS-1:0] present_tbl, alt_out_bus, alt_oe_bus, alt_in_bus;

  assign present_tbl = {ALT3_MAP, ALT2_MAP, ALT1_MAP};
  assign alt_out_bus = {alt3_out, alt2_out, alt1_out};
  assign alt_oe_bus  = {alt3_oe, alt2_oe, alt1_oe};
  assign alt1_in     = alt_in_bus[0];
  assign alt2_in     = alt_in_bus[1];
  assign alt3_in     = alt_in_bus[2];

  gpio_padmux_sync #(.WIDTH(NUM_PINS), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pad_in), .q(pin_sync)
  );

  gpio_padmux_regs #(.NUM_PINS(NUM_PINS)) u_regs (
    .clk(clk), .rst_n(rst_n), .addr(bus_addr), .we(bus_we), .wdata(bus_wdata),
    .sync_in(pin_sync), .out_q(gpio_out_q), .oe_q(gpio_oe_q),
    .sel_lo_q(sel_lo_q), .sel_hi_q(sel_hi_q),
    .ev_wr_set(ev_wr_set), .ev_wr_clr(ev_wr_clr), .rdata(bus_rdata)
  );

  gpio_padmux_route #(.NUM_PINS(NUM_PINS)) u_route (
    .sel_lo(sel_lo_q), .sel_hi(sel_hi_q), .gpio_out(gpio_out_q), .gpio_oe(gpio_oe_q),
    .pin_sync(pin_sync), .slot_present(present_tbl), .alt_out(alt_out_bus),
    .alt_oe(alt_oe_bus), .alt_in(alt_in_bus), .pad_out(pad_out), .pad_oe(pad_oe)
  );
endmodule

// File: rtl/gpio_padmux_chk.sv
module gpio_padmux_chk #(
  parameter int unsigned        NUM_PINS  = 22,
  parameter logic [NUM_PINS-1:0] ALT2_MAP = 22'h3EFFF0,
  parameter logic [NUM_PINS-1:0] ALT3_MAP = 22'h03FF30
) (
  input logic                clk,
  input logic                rst_n,
  input logic [31:0]         bus_wdata,
  input logic [31:0]         bus_rdata,
  input logic [NUM_PINS-1:0] pad_in,
  input logic [NUM_PINS-1:0] pad_out,
  input logic [NUM_PINS-1:0] pad_oe,
  input logic [NUM_PINS-1:0] gpio_out_q,
  input logic [NUM_PINS-1:0] gpio_oe_q,
  input logic [NUM_PINS-1:0] sel_lo_q,
  input logic [NUM_PINS-1:0] sel_hi_q,
  input logic [NUM_PINS-1:0] pin_sync,
  input logic                ev_wr_set,
  input logic                ev_wr_clr
);
  logic [1:0]          age_q;
  logic [NUM_PINS-1:0] wm, gpio_pins, empty_pins;

  assign wm         = bus_wdata[NUM_PINS-1:0];
  assign gpio_pins  = ~sel_lo_q & ~sel_hi_q;
  assign empty_pins = (sel_hi_q & ~sel_lo_q & ~ALT2_MAP) | (sel_hi_q & sel_lo_q & ~ALT3_MAP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) age_q <= '0;
    else if (age_q != 2'd2) age_q <= age_q + 2'd1;
  end

  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |=> (pad_oe == '0 && gpio_out_q == '0 && sel_lo_q == '0 && sel_hi_q == '0));

  assert_set_alias_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wr_set |=> ((gpio_out_q & $past(wm)) == $past(wm)) &&
                  ((gpio_out_q & ~$past(wm)) == ($past(gpio_out_q) & ~$past(wm))));

  assert_clr_alias_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wr_clr |=> ((gpio_out_q & $past(wm)) == '0) &&
                  ((gpio_out_q & ~$past(wm)) == ($past(gpio_out_q) & ~$past(wm))));

  assert_gpio_pad_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (((pad_oe ^ gpio_oe_q) | (pad_out ^ gpio_out_q)) & gpio_pins) == '0);

  assert_two_flop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q == 2'd2) |-> (pin_sync == $past(pad_in, 2)));

  assert_empty_slot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_oe | pad_out) & empty_pins) == '0);

  assert_upper_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[31:NUM_PINS] == '0);
endmodule

bind gpio_padmux gpio_padmux_chk #(
  .NUM_PINS(NUM_PINS), .ALT2_MAP(ALT2_MAP), .ALT3_MAP(ALT3_MAP)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
  .gpio_out_q(gpio_out_q), .gpio_oe_q(gpio_oe_q),
  .sel_lo_q(sel_lo_q), .sel_hi_q(sel_hi_q), .pin_sync(pin_sync),
  .ev_wr_set(ev_wr_set), .ev_wr_clr(ev_wr_clr)
);

// File: tb/gpio_padmux_tb.sv
module gpio_padmux_tb;
  localparam int NP = 22;
  localparam logic [NP-1:0] ALL = 22'h3FFFFF;

  typedef struct packed {
    logic [7:0]  waddr;
    logic [31:0] wdata;
    logic [7:0]  raddr;
    logic [31:0] exp;
  } vec_t;

  // R2 set, R3 clear, R4 direct value, R5 enable, R7 selects, R6 read-only, R11 upper/unmapped
  localparam vec_t VEC [12] = '{
    '{8'h08, 32'h0000_0000, 8'h08, 32'h0000_0000},
    '{8'h00, 32'h0000_00F0, 8'h08, 32'h0000_00F0},
    '{8'h00, 32'h0030_0001, 8'h08, 32'h0030_00F1},
    '{8'h04, 32'h0000_0030, 8'h08, 32'h0030_00C1},
    '{8'h04, 32'h0020_0000, 8'h08, 32'h0010_00C1},
    '{8'h08, 32'hFFFF_FFFF, 8'h08, 32'h003F_FFFF},
    '{8'h08, 32'h0012_3456, 8'h00, 32'h0000_0000},
    '{8'h10, 32'h0000_0F0F, 8'h10, 32'h0000_0F0F},
    '{8'h20, 32'hFFC0_0003, 8'h20, 32'h0000_0003},
    '{8'h24, 32'h0000_0002, 8'h24, 32'h0000_0002},
    '{8'h0C, 32'hFFFF_FFFF, 8'h08, 32'h0012_3456},
    '{8'h14, 32'hFFFF_FFFF, 8'h14, 32'h0000_0000}
  };

  logic clk = 1'b0, rst_n = 1'b0, bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [NP-1:0] pad_in = '0, pad_out, pad_oe;
  logic [NP-1:0] a1o = '0, a1e = '0, a1i, a2o = '0, a2e = '0, a2i, a3o = '0, a3e = '0, a3i;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  gpio_padmux u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe),
    .alt1_out(a1o), .alt1_oe(a1e), .alt1_in(a1i),
    .alt2_out(a2o), .alt2_oe(a2e), .alt2_in(a2i),
    .alt3_out(a3o), .alt3_oe(a3e), .alt3_in(a3i)
  );

  // Presence table restated from R9
  function automatic logic [NP-1:0] present(input int k);
    logic [NP-1:0] m = '0;
    for (int p = 0; p < NP; p++) begin
      case (k)
        1: m[p] = 1'b1;
        2: m[p] = !(p <= 3 || p == 16);
        default: m[p] = !(p <= 3 || p == 6 || p == 7 || p >= 18);
      endcase
    end
    return m;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog (all requirements) actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    // R1: state while reset is low
    check("R1 pad_oe in reset", {10'd0, pad_oe}, 32'h0);
    check("R1 pad_out in reset", {10'd0, pad_out}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    foreach (VEC[i]) begin
      if (i < 6) begin
        rd(VEC[i].raddr == 8'h08 ? 8'h10 : 8'h20, r);
        if (i == 0) check("R1 reset readback", r, 32'h0);
      end
    end
    rd(8'h24, r); check("R1 select-high after reset", r, 32'h0);

    foreach (VEC[i]) begin
      wr(VEC[i].waddr, VEC[i].wdata);
      rd(VEC[i].raddr, r);
      check($sformatf("R2/R3/R4/R5/R6/R7/R11 vector %0d", i), r, VEC[i].exp);
    end
    rd(8'h04, r); check("R3 clear alias reads 0", r, 32'h0);

    // R8: code 1 on every pin
    a1o = 22'h2AAAAA; a1e = ALL;
    wr(8'h24, 32'h0); wr(8'h20, {10'd0, ALL});
    check("R8 code1 pad_out", {10'd0, pad_out}, {10'd0, 22'h2AAAAA & present(1)});
    check("R8 code1 pad_oe", {10'd0, pad_oe}, {10'd0, present(1)});

    // R8/R9: code 2 on every pin
    a2o = ALL; a2e = ALL;
    wr(8'h20, 32'h0); wr(8'h24, {10'd0, ALL});
    check("R9 code2 pad_oe", {10'd0, pad_oe}, {10'd0, present(2)});
    check("R9 code2 pad_out", {10'd0, pad_out}, {10'd0, present(2)});

    // R9: code 3 on every pin
    a3o = ALL; a3e = ALL;
    wr(8'h20, {10'd0, ALL});
    check("R9 code3 pad_oe", {10'd0, pad_oe}, {10'd0, present(3)});

    // R10: peripheral inputs follow synchronized pad level for the selected slot
    @(negedge clk); pad_in = ALL;
    repeat (2) @(negedge clk);
    check("R10 alt3_in", {10'd0, a3i}, {10'd0, present(3)});
    check("R10 alt1_in unselected", {10'd0, a1i}, 32'h0);
    check("R10 alt2_in unselected", {10'd0, a2i}, 32'h0);

    // R5/R7: back to GPIO
    wr(8'h20, 32'h0); wr(8'h24, 32'h0);
    wr(8'h10, {10'd0, ALL}); wr(8'h08, 32'h0015_5555);
    check("R5 gpio pad_out", {10'd0, pad_out}, 32'h0015_5555);
    check("R5 gpio pad_oe", {10'd0, pad_oe}, {10'd0, ALL});
    check("R7 code0 ignores alt inputs", {10'd0, a3i}, 32'h0);

    // R6: two-edge synchronizer latency
    @(negedge clk); pad_in = '0;
    repeat (3) @(negedge clk);
    pad_in = 22'h00002C;
    @(negedge clk);
    rd(8'h0C, r); check("R6 after one edge", r, 32'h0);
    @(negedge clk);
    rd(8'h0C, r); check("R6 after two edges", r, 32'h0000_002C);

    // R7/R9: mixed codes, pin 5 code 3 present, pin 16 code 2 empty
    wr(8'h10, 32'h0);
    a2e = ALL; a3e = 22'h000020; a3o = 22'h000020;
    wr(8'h20, 32'h0000_0020); wr(8'h24, 32'h0001_0020);
    check("R7 mixed pad_oe", {10'd0, pad_oe}, 32'h0000_0020);
    check("R9 pin16 empty pad_out", {31'd0, pad_out[16]}, 32'h0);

    // R1: reset in mid-run clears everything
    @(negedge clk); rst_n = 1'b0;
    #1;
    check("R1 mid-run reset pad_oe", {10'd0, pad_oe}, 32'h0);
    rd(8'h08, r); check("R1 mid-run reset out", r, 32'h0);
    rd(8'h20, r); check("R1 mid-run reset select", r, 32'h0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule